// File: doc/BRIEF.md
# Security Coprocessor FIFO Status Controller

This block sits behind a byte-wide register port of a security coprocessor's FIFO host interface. It keeps the handshake status that the host polls: a status byte, a 16-bit burst count and an extended status byte. It moves each command through its life. The host asks for readiness and streams command bytes in. It sets go, the command engine executes, and the engine reports a response length. The host then drains the response through the data port. The host may re-read the response from its start (retry) or abort execution (cancel).

An abstracted engine sits on the other side. It receives each accepted command byte as a push strobe, gets a start pulse on go and an abort pulse on an honoured cancel, and returns `exec_done` with a response length. It serves response bytes from the address this block presents. The command length comes from a 32-bit big-endian size field in command bytes 2..5.

Internally a seven-state sequencer drives the flow:
- `ST_IDLE` goes to `ST_READY` on a ready request.
- `ST_READY` goes to `ST_RECV` on a command byte, or straight to `ST_LOADED` if that byte completes the command.
- `ST_RECV` goes to `ST_LOADED` on the final command byte.
- `ST_LOADED` goes to `ST_EXEC` on go.
- `ST_EXEC` goes to `ST_RESP` on completion with a non-zero length, or to `ST_DONE` on completion with zero length.
- `ST_RESP` goes to `ST_DONE` when the last response byte is read. A retry keeps it in `ST_RESP` and rewinds the pointer.
- `ST_DONE` goes to `ST_READY` on a ready request, or to `ST_RESP` on retry if a response exists.

Top module: `sfc_status_ctrl`

## Requirements
- R1: After reset the status byte (select 0) reads 0x80 with `selftest_done` low. Status bit 2 mirrors `selftest_done`. Status bit 7 is valid, bit 6 is ready, bit 4 is response available and bit 3 is expecting more bytes.
- R2: Writing status with bit 6 set is honoured only in idle or completion. It enters the ready phase: ready=1, expect=1, command count and response pointer cleared. Elsewhere it is ignored.
- R3: A data write (select 4) is accepted only in the ready or receiving phases, and is forwarded on `cmd_push`/`cmd_data`. Expect stays 1 until the number of accepted bytes equals the big-endian length in bytes 2..5. Data writes in any other phase are not forwarded.
- R4: Writing status bit 5 (go) once the command is complete gives exactly one `exec_start` pulse. It also clears ready and expect. A go in any other phase gives no pulse.
- R5: On `exec_done` during execution, the length on `exec_rsp_len` is latched. Response-available becomes 1 when that length is non-zero.
- R6: Each data read (select 4 with `host_rd_en`) during the response phase returns `rsp_byte` for addresses 0,1,2,… in turn. Response-available clears after the last byte. A data read outside the response phase returns 0xFF.
- R7: Writing status bit 1 (retry) in the response or completion phase, with a non-zero response, rewinds readout to byte 0 and sets response-available.
- R8: Writing extended status bit 0 (cancel) pulses `exec_abort` only during execution, and not in the cycle `exec_done` is high. In every other phase it has no effect.
- R9: The extended status byte (select 3) reads 0x04: family code 01 in bits 3:2, and cancel reads 0.
- R10: In the cycle after any register write, bit 7 reads 0 and bits 4 and 3 are masked to 0. Without a write, bit 7 reads 1.
- R11: The burst count (selects 1 low, 2 high) is min(remaining, MAX_BURST). Remaining is the bytes still owed once the length is known, or MAX_BURST before that. The same rule applies to the response bytes still unread during readout. It reads 0 in every other phase.
- R12: Go and retry bits always read back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Register write strobe |
| host_wr_sel | input | 3 | Write target: 0 status, 3 extended, 4 data |
| host_wr_data | input | 8 | Write byte |
| host_rd_en | input | 1 | Read strobe (pops response data on select 4) |
| host_rd_sel | input | 3 | Read target: 0 status, 1/2 burst low/high, 3 extended, 4 data |
| host_rd_data | output | 8 | Read byte (combinational) |
| cmd_push | output | 1 | Accepted command byte strobe |
| cmd_data | output | 8 | Command byte to engine |
| exec_start | output | 1 | Start pulse to engine |
| exec_abort | output | 1 | Cancel pulse to engine |
| exec_done | input | 1 | Engine finished, response ready |
| exec_rsp_len | input | CNT_W | Response length in bytes |
| rsp_addr | output | CNT_W | Response byte address being read |
| rsp_byte | input | 8 | Response byte at `rsp_addr` |
| selftest_done | input | 1 | Self-test completion flag |

## Verification
Two functions can meet in one cycle: a host cancel and the engine's completion. The bench writes cancel in the very cycle `exec_done` is high. The judgement is that completion wins: no abort pulse is counted and response-available is set on the next poll. Retry and ready requests in the completion phase are also tried. The sweep covers four command lengths against six response lengths, including zero and values either side of the burst limit.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READY  = 3'd1,
        ST_RECV   = 3'd2,
        ST_LOADED = 3'd3,
        ST_EXEC   = 3'd4,
        ST_RESP   = 3'd5,
        ST_DONE   = 3'd6
    } sfc_state_e;

    localparam logic [2:0] SEL_STATUS   = 3'd0;
    localparam logic [2:0] SEL_BURST_LO = 3'd1;
    localparam logic [2:0] SEL_BURST_HI = 3'd2;
    localparam logic [2:0] SEL_EXT      = 3'd3;
    localparam logic [2:0] SEL_DATA     = 3'd4;

    localparam int B_VALID    = 7;
    localparam int B_READY    = 6;
    localparam int B_GO       = 5;
    localparam int B_AVAIL    = 4;
    localparam int B_EXPECT   = 3;
    localparam int B_SELFTEST = 2;
    localparam int B_RETRY    = 1;
    localparam int B_CANCEL   = 0;

    localparam logic [1:0] FAMILY_CODE = 2'b01;

endpackage

// File: rtl/sfc_fsm.sv
module sfc_fsm
    import sfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ready,
    input  logic       wr_go,
    input  logic       wr_retry,
    input  logic       wr_byte,
    input  logic       rd_byte,
    input  logic       done,
    input  logic       cmd_last,
    input  logic       rsp_last,
    input  logic       rsp_zero,
    input  logic       rsp_has,
    output sfc_state_e state,
    output logic       acc_ready,
    output logic       acc_byte,
    output logic       acc_go,
    output logic       acc_done,
    output logic       acc_retry,
    output logic       acc_read
);

    sfc_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt       = state;
        acc_ready = 1'b0;
        acc_byte  = 1'b0;
        acc_go    = 1'b0;
        acc_done  = 1'b0;
        acc_retry = 1'b0;
        acc_read  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (wr_ready) begin
                    acc_ready = 1'b1;
                    nxt       = ST_READY;
                end
            end
            ST_READY, ST_RECV: begin
                if (wr_byte) begin
                    acc_byte = 1'b1;
                    nxt      = cmd_last ? ST_LOADED : ST_RECV;
                end
            end
            ST_LOADED: begin
                if (wr_go) begin
                    acc_go = 1'b1;
                    nxt    = ST_EXEC;
                end
            end
            ST_EXEC: begin
                if (done) begin
                    acc_done = 1'b1;
                    nxt      = rsp_zero ? ST_DONE : ST_RESP;
                end
            end
            ST_RESP: begin
                if (wr_retry) begin
                    acc_retry = 1'b1;
                end else if (rd_byte) begin
                    acc_read = 1'b1;
                    if (rsp_last) nxt = ST_DONE;
                end
            end
            ST_DONE: begin
                if (wr_ready) begin
                    acc_ready = 1'b1;
                    nxt       = ST_READY;
                end else if (wr_retry && rsp_has) begin
                    acc_retry = 1'b1;
                    nxt       = ST_RESP;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/sfc_cmd_track.sv
module sfc_cmd_track #(
    parameter int CNT_W     = 16,
    parameter int MAX_BURST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [7:0]       data,
    output logic             cmd_last,
    output logic [CNT_W-1:0] cmd_burst
);

    localparam int LEN_W = 32;
    localparam logic [LEN_W-1:0] BURST_L = LEN_W'(MAX_BURST);

    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] cnt_ext;
    logic [LEN_W-1:0] next_len;
    logic [LEN_W-1:0] remain;
    logic             in_size_field;
    logic             len_known;

    assign cnt_ext       = LEN_W'(cnt);
    assign in_size_field = (cnt_ext >= 32'd2) && (cnt_ext <= 32'd5);
    assign next_len      = in_size_field ? {len[LEN_W-9:0], data} : len;
    assign cmd_last      = (cnt_ext >= 32'd5) && ((cnt_ext + 32'd1) >= next_len);
    assign len_known     = (cnt_ext >= 32'd6);
    assign remain        = (len > cnt_ext) ? (len - cnt_ext) : '0;

    always_comb begin
        if (!len_known)          cmd_burst = CNT_W'(MAX_BURST);
        else if (remain > BURST_L) cmd_burst = CNT_W'(MAX_BURST);
        else                     cmd_burst = CNT_W'(remain);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
            len <= '0;
        end else if (push) begin
            cnt <= cnt + 1'b1;
            len <= next_len;
        end
    end

endmodule

// File: rtl/sfc_rsp_track.sv
module sfc_rsp_track #(
    parameter int CNT_W     = 16,
    parameter int MAX_BURST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    input  logic             rewind,
    input  logic             adv,
    output logic [CNT_W-1:0] ptr,
    output logic [CNT_W-1:0] len,
    output logic             rsp_last,
    output logic             rsp_has,
    output logic [CNT_W-1:0] rsp_burst
);

    localparam logic [CNT_W-1:0] BURST_C = CNT_W'(MAX_BURST);

    logic [CNT_W-1:0] remain;

    assign remain    = (len > ptr) ? (len - ptr) : '0;
    assign rsp_last  = ((ptr + 1'b1) == len);
    assign rsp_has   = (len != '0);
    assign rsp_burst = (remain > BURST_C) ? BURST_C : remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            len <= '0;
        end else if (load) begin
            ptr <= '0;
            len <= load_len;
        end else if (rewind) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/sfc_status_ctrl.sv
module sfc_status_ctrl
    import sfc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int MAX_BURST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr_en,
    input  logic [2:0]       host_wr_sel,
    input  logic [7:0]       host_wr_data,
    input  logic             host_rd_en,
    input  logic [2:0]       host_rd_sel,
    output logic [7:0]       host_rd_data,
    output logic             cmd_push,
    output logic [7:0]       cmd_data,
    output logic             exec_start,
    output logic             exec_abort,
    input  logic             exec_done,
    input  logic [CNT_W-1:0] exec_rsp_len,
    output logic [CNT_W-1:0] rsp_addr,
    input  logic [7:0]       rsp_byte,
    input  logic             selftest_done
);

    sfc_state_e       state;
    logic             wr_status, wr_ext, wr_data, rd_data;
    logic             acc_ready, acc_byte, acc_go, acc_done, acc_retry, acc_read;
    logic             cmd_last, rsp_last, rsp_has;
    logic [CNT_W-1:0] cmd_burst, rsp_burst, rsp_len;
    logic [15:0]      burst;
    logic             wr_seen;
    logic             valid;
    logic [7:0]       stat_byte;
    logic [7:0]       ext_byte;

    assign wr_status = host_wr_en && (host_wr_sel == SEL_STATUS);
    assign wr_ext    = host_wr_en && (host_wr_sel == SEL_EXT);
    assign wr_data   = host_wr_en && (host_wr_sel == SEL_DATA);
    assign rd_data   = host_rd_en && (host_rd_sel == SEL_DATA);

    sfc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ready  (wr_status && host_wr_data[B_READY]),
        .wr_go     (wr_status && host_wr_data[B_GO]),
        .wr_retry  (wr_status && host_wr_data[B_RETRY]),
        .wr_byte   (wr_data),
        .rd_byte   (rd_data),
        .done      (exec_done),
        .cmd_last  (cmd_last),
        .rsp_last  (rsp_last),
        .rsp_zero  (exec_rsp_len == '0),
        .rsp_has   (rsp_has),
        .state     (state),
        .acc_ready (acc_ready),
        .acc_byte  (acc_byte),
        .acc_go    (acc_go),
        .acc_done  (acc_done),
        .acc_retry (acc_retry),
        .acc_read  (acc_read)
    );

    sfc_cmd_track #(.CNT_W(CNT_W), .MAX_BURST(MAX_BURST)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (acc_ready),
        .push      (acc_byte),
        .data      (host_wr_data),
        .cmd_last  (cmd_last),
        .cmd_burst (cmd_burst)
    );

    sfc_rsp_track #(.CNT_W(CNT_W), .MAX_BURST(MAX_BURST)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (acc_done),
        .load_len  (exec_rsp_len),
        .rewind    (acc_retry || acc_ready),
        .adv       (acc_read),
        .ptr       (rsp_addr),
        .len       (rsp_len),
        .rsp_last  (rsp_last),
        .rsp_has   (rsp_has),
        .rsp_burst (rsp_burst)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) wr_seen <= 1'b0;
        else        wr_seen <= host_wr_en;
    end

    assign valid = !wr_seen;

    always_comb begin
        stat_byte             = '0;
        stat_byte[B_VALID]    = valid;
        stat_byte[B_READY]    = (state == ST_READY) || (state == ST_RECV) || (state == ST_LOADED);
        stat_byte[B_AVAIL]    = valid && (state == ST_RESP);
        stat_byte[B_EXPECT]   = valid && ((state == ST_READY) || (state == ST_RECV));
        stat_byte[B_SELFTEST] = selftest_done;
        ext_byte              = {4'b0000, FAMILY_CODE, 2'b00};
        unique case (state)
            ST_READY, ST_RECV: burst = 16'(cmd_burst);
            ST_RESP:           burst = 16'(rsp_burst);
            default:           burst = '0;
        endcase
    end

    always_comb begin
        unique case (host_rd_sel)
            SEL_STATUS:   host_rd_data = stat_byte;
            SEL_BURST_LO: host_rd_data = burst[7:0];
            SEL_BURST_HI: host_rd_data = burst[15:8];
            SEL_EXT:      host_rd_data = ext_byte;
            SEL_DATA:     host_rd_data = (state == ST_RESP) ? rsp_byte : 8'hFF;
            default:      host_rd_data = 8'h00;
        endcase
    end

    assign cmd_push   = acc_byte;
    assign cmd_data   = host_wr_data;
    assign exec_start = acc_go;
    assign exec_abort = wr_ext && host_wr_data[B_CANCEL] && (state == ST_EXEC) && !exec_done;

endmodule

// File: rtl/sfc_status_ctrl_chk.sv
module sfc_status_ctrl_chk
    import sfc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr_en,
    input logic             exec_start,
    input logic             exec_abort,
    input logic [7:0]       stat_byte,
    input sfc_state_e       state,
    input logic [CNT_W-1:0] ptr,
    input logic [CNT_W-1:0] rlen
);

    a_r10_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_en |=> !stat_byte[B_VALID]);

    a_r10_valid_returns: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr_en |=> stat_byte[B_VALID]);

    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_byte[B_AVAIL] && stat_byte[B_EXPECT]));

    a_r4_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> !exec_start);

    a_r4_start_enters_exec: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> (state == ST_EXEC) && !stat_byte[B_READY]);

    a_r8_abort_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        exec_abort |=> !stat_byte[B_AVAIL]);

    a_r6_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESP) |-> (ptr < rlen));

endmodule

bind sfc_status_ctrl sfc_status_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr_en (host_wr_en),
    .exec_start (exec_start),
    .exec_abort (exec_abort),
    .stat_byte  (stat_byte),
    .state      (state),
    .ptr        (rsp_addr),
    .rlen       (rsp_len)
);

// File: tb/sfc_status_ctrl_test.sv
`timescale 1ns/1ps
module sfc_status_ctrl_test;

    localparam int CNT_W = 16;
    localparam int MB    = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_wr_en = 1'b0;
    logic [2:0]       host_wr_sel = '0;
    logic [7:0]       host_wr_data = '0;
    logic             host_rd_en = 1'b0;
    logic [2:0]       host_rd_sel = '0;
    logic [7:0]       host_rd_data;
    logic             cmd_push;
    logic [7:0]       cmd_data;
    logic             exec_start, exec_abort;
    logic             exec_done = 1'b0;
    logic [CNT_W-1:0] exec_rsp_len = '0;
    logic [CNT_W-1:0] rsp_addr;
    logic [7:0]       rsp_byte;
    logic             selftest_done = 1'b0;

    int n_checks = 0, n_fail = 0;
    int n_start = 0, n_abort = 0, n_push = 0;
    logic [7:0] last_push = '0;

    always #2.5 clk = ~clk;

    assign rsp_byte = rsp_addr[7:0] ^ 8'h5A;

    sfc_status_ctrl #(.CNT_W(CNT_W), .MAX_BURST(MB)) uut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_sel(host_rd_sel), .host_rd_data(host_rd_data),
        .cmd_push(cmd_push), .cmd_data(cmd_data),
        .exec_start(exec_start), .exec_abort(exec_abort),
        .exec_done(exec_done), .exec_rsp_len(exec_rsp_len),
        .rsp_addr(rsp_addr), .rsp_byte(rsp_byte), .selftest_done(selftest_done)
    );

    always @(posedge clk) begin
        if (exec_start) n_start <= n_start + 1;
        if (exec_abort) n_abort <= n_abort + 1;
        if (cmd_push) begin
            n_push    <= n_push + 1;
            last_push <= cmd_data;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    function automatic int stx(input bit v, input bit r, input bit a, input bit e);
        return {v, r, 1'b0, a & v, e & v, selftest_done, 2'b00};
    endfunction

    function automatic int mn(input int a);
        return (a > MB) ? MB : a;
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        host_wr_en = 1'b1; host_wr_sel = sel; host_wr_data = d;
        @(posedge clk); #1;
        host_wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] sel, output int v);
        host_rd_sel = sel; #0.5;
        v = host_rd_data;
    endtask

    task automatic pop(output int v);
        host_rd_sel = 3'd4; host_rd_en = 1'b1; #0.5;
        v = host_rd_data;
        @(posedge clk); #1;
        host_rd_en = 1'b0;
    endtask

    task automatic burst(output int v);
        int lo, hi;
        peek(3'd1, lo); peek(3'd2, hi);
        v = hi * 256 + lo;
    endtask

    task automatic finish_exec(input int len);
        exec_rsp_len = CNT_W'(len); exec_done = 1'b1;
        @(posedge clk); #1;
        exec_done = 1'b0;
    endtask

    task automatic send_cmd(input int L);
        int b;
        for (int i = 0; i < L; i++) begin
            logic [7:0] d;
            if (i < 2)       d = 8'h80 + 8'(i);
            else if (i < 6)  d = 8'(L >> (8 * (5 - i)));
            else             d = 8'(i * 3);
            if (i >= 6) begin
                burst(b); check("R11 command burst", b, mn(L - i));
            end
            if (i == L - 1) begin
                tick(); peek(3'd0, b);
                check("R3 expect before last byte", b, stx(1, 1, 0, 1));
            end
            wr(3'd4, d);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        int v, b, pushes, aborts;
        int lens[4]  = '{6, 7, 10, 13};
        int rlens[6] = '{0, 1, 3, 8, 9, 12};

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset view, R9 extended, R11 idle burst, R6 idle data
        peek(3'd0, v); check("R1 reset status", v, 8'h80);
        peek(3'd3, v); check("R9 extended status", v, 8'h04);
        burst(b);      check("R11 idle burst", b, 0);
        peek(3'd4, v); check("R6 idle data read", v, 8'hFF);
        wr(3'd0, 8'h20); tick();
        check("R4 go ignored in idle", n_start, 0);
        wr(3'd4, 8'h11); tick();
        check("R3 data ignored in idle", n_push, 0);

        for (int li = 0; li < 4; li++) begin
            for (int ri = 0; ri < 6; ri++) begin
                int L, R;
                L = lens[li]; R = rlens[ri];
                pushes = n_push;
                wr(3'd0, 8'h40);
                peek(3'd0, v); check("R10 masked after write", v, stx(0, 1, 0, 1));
                tick();
                peek(3'd0, v); check("R2 ready entered", v, stx(1, 1, 0, 1));
                burst(b);      check("R11 burst before length", b, MB);
                send_cmd(L);
                tick();
                peek(3'd0, v); check("R3 expect cleared", v, stx(1, 1, 0, 0));
                check("R3 pushed count", n_push - pushes, L);
                wr(3'd4, 8'hEE); tick();
                check("R3 extra byte ignored", n_push - pushes, L);
                wr(3'd0, 8'h20); tick();
                check("R4 one start", n_start, li * 6 + ri + 1);
                peek(3'd0, v); check("R4 R12 exec status", v, stx(1, 0, 0, 0));
                wr(3'd0, 8'h40); tick();
                peek(3'd0, v); check("R2 ready ignored in exec", v, stx(1, 0, 0, 0));
                aborts = n_abort;
                if (((li + ri) % 2) == 0) begin
                    wr(3'd3, 8'h01); tick();
                    check("R8 cancel in exec", n_abort - aborts, 1);
                    aborts = n_abort;
                end
                finish_exec(R); tick();
                peek(3'd0, v); check("R5 avail after done", v, stx(1, 0, R != 0, 0));
                burst(b); check("R11 response burst", b, mn(R));
                for (int k = 0; k < R; k++) begin
                    burst(b); check("R11 burst during read", b, mn(R - k));
                    pop(v); check("R6 response byte", v, (k ^ 8'h5A));
                end
                peek(3'd0, v); check("R6 avail cleared", v, stx(1, 0, 0, 0));
                pop(v); check("R6 read past end", v, 8'hFF);
                wr(3'd3, 8'h01); tick();
                check("R8 cancel after response ignored", n_abort - aborts, 0);
                peek(3'd0, v); check("R8 state unchanged", v, stx(1, 0, 0, 0));
                if (R >= 2) begin
                    pop(v);
                    wr(3'd0, 8'h02); tick();
                    peek(3'd0, v); check("R7 retry rearms", v, stx(1, 0, 1, 0));
                    pop(v); check("R7 first byte again", v, 8'h5A);
                    wr(3'd0, 8'h02); tick();
                    for (int k = 0; k < R; k++) begin
                        pop(v); check("R7 replay byte", v, (k ^ 8'h5A));
                    end
                    peek(3'd0, v); check("R12 retry reads zero", v, stx(1, 0, 0, 0));
                end
            end
        end

        // cancel coinciding with completion: completion wins (R8)
        wr(3'd0, 8'h40); tick();
        send_cmd(6);
        wr(3'd0, 8'h20); tick();
        aborts = n_abort;
        exec_rsp_len = 16'd4; exec_done = 1'b1;
        host_wr_en = 1'b1; host_wr_sel = 3'd3; host_wr_data = 8'h01;
        @(posedge clk); #1;
        exec_done = 1'b0; host_wr_en = 1'b0;
        tick();
        check("R8 no abort with done", n_abort - aborts, 0);
        peek(3'd0, v); check("R5 avail after coincident", v, stx(1, 0, 1, 0));
        for (int k = 0; k < 4; k++) pop(v);
        // ready and retry together in completion: ready wins (R2)
        wr(3'd0, 8'h42); tick();
        peek(3'd0, v); check("R2 ready beats retry", v, stx(1, 1, 0, 1));

        selftest_done = 1'b1; #1;
        peek(3'd0, v); check("R1 selftest bit", v, 8'hCC);
        summary();
    end

endmodule